// File: doc/BRIEF.md
# Reference Window Row Store

This block holds the reference search area for a block-matching datapath. It keeps it in sixteen byte-wide memory banks that are read side by side. A pixel's column picks its bank and the low part of its bank word. Its row picks the upper part of that word. With this layout, any sixteen horizontally adjacent pixels fall into sixteen different banks. A loader fills the store one pixel per cycle, giving the pixel's window row and column. A matcher then asks for a row and a starting column, and one cycle later it receives sixteen pixels in left-to-right order.

The window is 32 columns wide and 16 rows tall at the default parameters, and both coordinates wrap. Each bank computes its own word address, using only additions, masks and shifts. A bank whose index lies below the start column, in modulo-16 order, belongs to the next block of sixteen columns. A barrel rotator after the banks moves the pixel at the start column into lane 0.

Top module: `refwin_store`

## Requirements
- R1: While reset is asserted and after it is released, before any read, `rd_valid` is 0 and `rd_pix` is all zeros.
- R2: A write with `wr_en` high stores `wr_pix` at window position (`wr_row`, `wr_col`). Exactly one bank is enabled per write, namely bank `wr_col` mod 16. No other stored pixel changes.
- R3: A read asked for with `rd_en` high at one clock edge presents its result at the next edge with `rd_valid` high. Back-to-back reads give one result per cycle.
- R4: Lane j of a read result occupies bits 8j+7 down to 8j of `rd_pix`. It holds the pixel at row `rd_row` and column `rd_col`+j. All sixteen lanes come from the same row.
- R5: A read at any start column, from 0 to 31, returns correct data. This includes runs that cross the boundary at column 16 and runs that wrap from column 31 back to column 0.
- R6: A read and a write in the same cycle return the pixel as it was before that write. The new value is seen by later reads.
- R7: When `rd_en` is low, `rd_pix` keeps the last read result, even if writes change the pixels it came from.
- R8: `rd_valid` is low in every cycle that does not follow a read request.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous reset, active low |
| wr_en | input | 1 | Store one pixel this cycle |
| wr_row | input | 4 | Window row of the stored pixel |
| wr_col | input | 5 | Window column of the stored pixel |
| wr_pix | input | 8 | Pixel value to store |
| rd_en | input | 1 | Request a sixteen-pixel row run |
| rd_row | input | 4 | Window row of the run |
| rd_col | input | 5 | Window column of the leftmost pixel of the run |
| rd_valid | output | 1 | Run result present on `rd_pix` |
| rd_pix | output | 128 | Sixteen pixels, lane 0 = leftmost |

## Verification
A stale rotation amount shows up as lanes shifted as a group. It appears in the very result that follows the read request, so a sweep over all start columns finds it within one cycle of the faulty read. A wrong block choice for the banks below the start column changes only the lanes that lie past the sixteen-column boundary. This is why the sweep has to include unaligned and wrapping starts. A bad write decode damages stored pixels without any sign at the ports until that pixel is read. For this reason the whole window is filled with position-dependent values and then read back at every alignment.

// File: rtl/refwin_pkg.sv
package refwin_pkg;

  // Default geometry of the store
  localparam int unsigned DEF_LANES = 16;
  localparam int unsigned DEF_PIX_W = 8;
  localparam int unsigned DEF_WIN_W = 32;
  localparam int unsigned DEF_WIN_H = 16;

  // Bank that owns a column: low column bits
  function automatic int unsigned bank_of(int unsigned col, int unsigned lane_bits);
    return col & ((32'd1 << lane_bits) - 32'd1);
  endfunction

  // Sixteen-column block that a column belongs to
  function automatic int unsigned block_of(int unsigned col, int unsigned lane_bits,
                                           int unsigned blk_bits);
    return (col >> lane_bits) & ((32'd1 << blk_bits) - 32'd1);
  endfunction

  // Bank word: row in the upper bits, block in the lower bits (shift only)
  function automatic int unsigned word_of(int unsigned row, int unsigned blk,
                                          int unsigned blk_bits);
    return (row << blk_bits) | blk;
  endfunction

  // Block a bank serves for a run starting at start_col; banks below the
  // start bank hold the next block (wrap adjustment)
  function automatic int unsigned read_block(int unsigned start_col, int unsigned bank,
                                             int unsigned lane_bits, int unsigned blk_bits);
    int unsigned blk;
    blk = block_of(start_col, lane_bits, blk_bits);
    if (bank < bank_of(start_col, lane_bits)) blk = blk + 32'd1;
    return blk & ((32'd1 << blk_bits) - 32'd1);
  endfunction

endpackage

// File: rtl/refwin_bank.sv
module refwin_bank #(
  parameter int unsigned PIX_W = 8,
  parameter int unsigned DEPTH = 32,
  parameter int unsigned AW    = 5
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             we,
  input  logic [AW-1:0]    waddr,
  input  logic [PIX_W-1:0] wdata,
  input  logic             re,
  input  logic [AW-1:0]    raddr,
  output logic [PIX_W-1:0] rdata
);

  logic [PIX_W-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
  end

  // Registered read returns the word as it was before this edge
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)  rdata <= '0;
    else if (re) rdata <= mem[raddr];
  end

endmodule

// File: rtl/refwin_addr_gen.sv
module refwin_addr_gen
  import refwin_pkg::*;
#(
  parameter int unsigned LANES = 16,
  parameter int unsigned LB    = 4,
  parameter int unsigned BB    = 1,
  parameter int unsigned AW    = 5,
  parameter int unsigned RW    = 4,
  parameter int unsigned CW    = 5
) (
  input  logic                       wr_en,
  input  logic [RW-1:0]              wr_row,
  input  logic [CW-1:0]              wr_col,
  input  logic [RW-1:0]              rd_row,
  input  logic [CW-1:0]              rd_col,
  output logic [LANES-1:0]           bank_we,
  output logic [AW-1:0]              wr_word,
  output logic [LANES-1:0][AW-1:0]   rd_word
);

  logic [LB-1:0] wr_bank;

  assign wr_bank = LB'(bank_of(32'(wr_col), LB));
  assign wr_word = AW'(word_of(32'(wr_row), block_of(32'(wr_col), LB, BB), BB));

  for (genvar b = 0; b < LANES; b++) begin : g_lane_addr
    assign bank_we[b] = wr_en && (wr_bank == LB'(b));
    assign rd_word[b] = AW'(word_of(32'(rd_row),
                                    read_block(32'(rd_col), b, LB, BB), BB));
  end

endmodule

// File: rtl/refwin_rotator.sv
module refwin_rotator #(
  parameter int unsigned LANES = 16,
  parameter int unsigned PIX_W = 8,
  parameter int unsigned LB    = 4
) (
  input  logic [LANES*PIX_W-1:0] din,
  input  logic [LB-1:0]          shift,
  output logic [LANES*PIX_W-1:0] dout
);

  localparam int unsigned TW = LANES * PIX_W;

  logic [LB:0][TW-1:0] stage;

  assign stage[0] = din;

  // Log-depth barrel: stage k moves lanes down by 2^k when its bit is set
  for (genvar k = 0; k < LB; k++) begin : g_stage
    localparam int unsigned SW = (1 << k) * PIX_W;
    assign stage[k+1] = shift[k] ? {stage[k][SW-1:0], stage[k][TW-1:SW]} : stage[k];
  end

  assign dout = stage[LB];

endmodule

// File: rtl/refwin_store.sv
module refwin_store
  import refwin_pkg::*;
#(
  parameter int unsigned LANES = DEF_LANES,
  parameter int unsigned PIX_W = DEF_PIX_W,
  parameter int unsigned WIN_W = DEF_WIN_W,
  parameter int unsigned WIN_H = DEF_WIN_H
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      wr_en,
  input  logic [$clog2(WIN_H)-1:0]  wr_row,
  input  logic [$clog2(WIN_W)-1:0]  wr_col,
  input  logic [PIX_W-1:0]          wr_pix,
  input  logic                      rd_en,
  input  logic [$clog2(WIN_H)-1:0]  rd_row,
  input  logic [$clog2(WIN_W)-1:0]  rd_col,
  output logic                      rd_valid,
  output logic [LANES*PIX_W-1:0]    rd_pix
);

  localparam int unsigned LB    = $clog2(LANES);
  localparam int unsigned NBLK  = WIN_W / LANES;
  localparam int unsigned BB    = $clog2(NBLK);
  localparam int unsigned DEPTH = WIN_H * NBLK;
  localparam int unsigned AW    = $clog2(DEPTH);
  localparam int unsigned RW    = $clog2(WIN_H);
  localparam int unsigned CW    = $clog2(WIN_W);

  // Named internal events, observed by the bound checker
  logic [LANES-1:0]              bank_we;
  logic [AW-1:0]                 wr_word;
  logic [LANES-1:0][AW-1:0]      rd_word;
  logic [LANES*PIX_W-1:0]        bank_q;
  logic [LB-1:0]                 rd_shift_q;
  logic                          rd_valid_q;

  refwin_addr_gen #(
    .LANES(LANES), .LB(LB), .BB(BB), .AW(AW), .RW(RW), .CW(CW)
  ) u_addr (
    .wr_en   (wr_en),
    .wr_row  (wr_row),
    .wr_col  (wr_col),
    .rd_row  (rd_row),
    .rd_col  (rd_col),
    .bank_we (bank_we),
    .wr_word (wr_word),
    .rd_word (rd_word)
  );

  for (genvar b = 0; b < LANES; b++) begin : g_bank
    refwin_bank #(
      .PIX_W(PIX_W), .DEPTH(DEPTH), .AW(AW)
    ) u_bank (
      .clk   (clk),
      .rst_n (rst_n),
      .we    (bank_we[b]),
      .waddr (wr_word),
      .wdata (wr_pix),
      .re    (rd_en),
      .raddr (rd_word[b]),
      .rdata (bank_q[b*PIX_W +: PIX_W])
    );
  end

  // Rotation amount travels with the read through the bank register
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rd_shift_q <= '0;
      rd_valid_q <= 1'b0;
    end else begin
      rd_valid_q <= rd_en;
      if (rd_en) rd_shift_q <= rd_col[LB-1:0];
    end
  end

  refwin_rotator #(
    .LANES(LANES), .PIX_W(PIX_W), .LB(LB)
  ) u_rot (
    .din   (bank_q),
    .shift (rd_shift_q),
    .dout  (rd_pix)
  );

  assign rd_valid = rd_valid_q;

endmodule

// File: rtl/refwin_chk.sv
module refwin_chk #(
  parameter int unsigned LANES = 16,
  parameter int unsigned PIX_W = 8,
  parameter int unsigned LB    = 4,
  parameter int unsigned BB    = 1,
  parameter int unsigned AW    = 5
) (
  input logic                     clk,
  input logic                     rst_n,
  input logic                     rd_en,
  input logic [LB-1:0]            rd_lo,
  input logic                     rd_valid,
  input logic [LANES*PIX_W-1:0]   rd_pix,
  input logic                     wr_en,
  input logic [LANES-1:0]         bank_we,
  input logic [LANES-1:0][AW-1:0] rd_word
);

  p_valid_next_r3: assert property (@(posedge clk) disable iff (!rst_n)
    rd_en |=> rd_valid);

  p_valid_quiet_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_en |=> !rd_valid);

  p_hold_idle_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_en |=> $stable(rd_pix));

  p_one_bank_write_r2: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |-> $countones(bank_we) == 1);

  p_no_stray_write_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_en |-> bank_we == '0);

  for (genvar b = 0; b < LANES - 1; b++) begin : g_lane_chk
    // every bank reads the same row (R4)
    p_same_row_r4: assert property (@(posedge clk) disable iff (!rst_n)
      rd_en |-> rd_word[b][AW-1:BB] == rd_word[LANES-1][AW-1:BB]);
    // banks below the start bank serve the following block (R5)
    p_wrap_block_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (rd_en && (rd_lo > LB'(b))) |->
        rd_word[b][BB-1:0] == BB'(rd_word[LANES-1][BB-1:0] + 1'b1));
    p_same_block_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (rd_en && (rd_lo <= LB'(b))) |->
        rd_word[b][BB-1:0] == rd_word[LANES-1][BB-1:0]);
  end

endmodule

bind refwin_store refwin_chk #(
  .LANES(LANES), .PIX_W(PIX_W), .LB(LB), .BB(BB), .AW(AW)
) u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .rd_en    (rd_en),
  .rd_lo    (rd_col[LB-1:0]),
  .rd_valid (rd_valid),
  .rd_pix   (rd_pix),
  .wr_en    (wr_en),
  .bank_we  (bank_we),
  .rd_word  (rd_word)
);

// File: tb/refwin_store_test.sv
module refwin_store_test;

  localparam int CLK_PERIOD = 10;
  localparam int LANES = 16;
  localparam int PIX_W = 8;
  localparam int WIN_W = 32;
  localparam int WIN_H = 16;

  logic                   clk = 1'b0;
  logic                   rst_n;
  logic                   wr_en;
  logic [3:0]             wr_row;
  logic [4:0]             wr_col;
  logic [7:0]             wr_pix;
  logic                   rd_en;
  logic [3:0]             rd_row;
  logic [4:0]             rd_col;
  logic                   rd_valid;
  logic [LANES*PIX_W-1:0] rd_pix;

  int    vectors = 0;
  int    miscompares = 0;
  bit    running = 1'b0;
  bit    finished = 1'b0;
  string phase = "R1";
  string exp_tag = "R1";

  logic [7:0]             mdl [WIN_H][WIN_W];
  logic                   exp_valid = 1'b0;
  logic [LANES*PIX_W-1:0] exp_pix = '0;

  always #(CLK_PERIOD/2) clk = ~clk;

  refwin_store uut (
    .clk(clk), .rst_n(rst_n),
    .wr_en(wr_en), .wr_row(wr_row), .wr_col(wr_col), .wr_pix(wr_pix),
    .rd_en(rd_en), .rd_row(rd_row), .rd_col(rd_col),
    .rd_valid(rd_valid), .rd_pix(rd_pix)
  );

  // Behavioural reference: a plain 2-D pixel array, read before write
  always @(posedge clk) begin
    if (!rst_n) begin
      exp_valid = 1'b0;
      exp_pix   = '0;
    end else begin
      exp_tag = phase;
      if (rd_en)
        for (int j = 0; j < LANES; j++)
          exp_pix[j*PIX_W +: PIX_W] = mdl[rd_row][(int'(rd_col) + j) % WIN_W];
      exp_valid = rd_en;
      if (wr_en) mdl[wr_row][wr_col] = wr_pix;
    end
  end

  // Compare on every clock, away from the active edge
  always @(negedge clk) begin
    if (running && rst_n && !finished) begin
      vectors++;
      if (rd_valid !== exp_valid || rd_pix !== exp_pix) begin
        miscompares++;
        $display("FAIL %s: valid=%0b pix=%h, expected valid=%0b pix=%h",
                 exp_tag, rd_valid, rd_pix, exp_valid, exp_pix);
      end
    end
  end

  task automatic step(input bit we, input int wr, input int wc, input int wp,
                      input bit re, input int rr, input int rc);
    @(negedge clk);
    wr_en  = we;
    wr_row = 4'(wr);
    wr_col = 5'(wc);
    wr_pix = 8'(wp);
    rd_en  = re;
    rd_row = 4'(rr);
    rd_col = 5'(rc);
  endtask

  function automatic int pat(input int r, input int c);
    return (r * 37 + c * 5 + 1) & 255;
  endfunction

  task automatic finish_run();
    finished = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      miscompares++;
      $display("FAIL watchdog: run did not end, expected completion");
      finish_run();
    end
  end

  initial begin
    rst_n = 1'b0;
    wr_en = 0; wr_row = 0; wr_col = 0; wr_pix = 0;
    rd_en = 0; rd_row = 0; rd_col = 0;
    for (int r = 0; r < WIN_H; r++)
      for (int c = 0; c < WIN_W; c++) mdl[r][c] = 8'h00;
    repeat (3) @(negedge clk);
    // R1: outputs during reset
    vectors++;
    if (rd_valid !== 1'b0 || rd_pix !== '0) begin
      miscompares++;
      $display("FAIL R1: valid=%0b pix=%h, expected 0 and 0", rd_valid, rd_pix);
    end
    rst_n = 1'b1;
    running = 1'b1;
    step(0, 0, 0, 0, 0, 0, 0);           // R1 after release, compared by model

    phase = "R2";                          // fill every pixel
    for (int r = 0; r < WIN_H; r++)
      for (int c = 0; c < WIN_W; c++) step(1, r, c, pat(r, c), 0, 0, 0);

    phase = "R4";                          // aligned runs on every row
    for (int r = 0; r < WIN_H; r++) begin
      step(0, 0, 0, 0, 1, r, 0);
      step(0, 0, 0, 0, 1, r, 16);
    end

    phase = "R5";                          // every alignment, incl. wrap
    for (int c = 0; c < WIN_W; c++) step(0, 0, 0, 0, 1, 5, c);
    for (int c = 0; c < WIN_W; c += 3) step(0, 0, 0, 0, 1, 15, c);
    step(0, 0, 0, 0, 1, 0, 31);

    phase = "R3";                          // back-to-back reads
    for (int i = 0; i < 8; i++) step(0, 0, 0, 0, 1, (i % 2) ? 15 : 0, 7 + i);

    phase = "R6";                          // read and write same cycle
    step(1, 3, 12, 8'hA5, 1, 3, 10);
    step(0, 0, 0, 0, 1, 3, 10);
    step(1, 9, 1, 8'h3C, 1, 9, 20);        // write lands in wrapped lane
    step(0, 0, 0, 0, 1, 9, 20);

    phase = "R7";                          // hold while idle, despite writes
    step(0, 0, 0, 0, 1, 7, 20);
    for (int i = 0; i < 4; i++) step(1, 7, 20 + i, 8'hF0 + i, 0, 0, 0);
    step(0, 0, 0, 0, 1, 7, 20);

    phase = "R8";                          // valid low when idle
    for (int i = 0; i < 3; i++) step(0, 0, 0, 0, 0, 0, 0);

    phase = "R2";                          // overwrite and verify isolation
    for (int c = 0; c < WIN_W; c += 2) step(1, 11, c, 255 - c, 0, 0, 0);
    for (int c = 0; c < WIN_W; c += 5) step(0, 0, 0, 0, 1, 11, c);
    step(0, 0, 0, 0, 1, 10, 0);
    step(0, 0, 0, 0, 1, 12, 16);
    step(0, 0, 0, 0, 0, 0, 0);
    @(negedge clk);
    finish_run();
  end

endmodule